// File: doc/BRIEF.md
# Chained Readout Token Controller

This controller sits on each acquisition board of a crate and lets a row of neighbouring boards act as one slave during a chained block read or a multicast write. All boards answer at one shared address. A single token, carried on the interrupt-acknowledge daisy chain (token in, token out, both active low), decides which board owns the bus at any moment. The master runs an ordinary block read or single write and sees one unbroken transfer. All inputs are assumed already synchronized to `clk`.

In a chained read the owner answers each data strobe with one event word from a local stream source. When its words for the event run out, it passes the token on and goes quiet. The board configured as last does not pass the token. Instead it ends the master's cycle with a bus error. In a multicast write each owner latches the write data on the data strobe and passes the token at once. Only the last board acknowledges. Releasing the address strobe returns every board to idle.

The event words enter on a valid/ready stream. A word moves on a clock edge where `word_valid` and `word_ready` are both high. `word_ready` never depends on `word_valid`. The source must keep `word_valid` high for as long as it holds words of the current event. An owner that sees `word_valid` low between strobes takes the event as finished. `word_last` marks the final word of the event.

Top module: `chain_token_ctrl`

## Requirements
- R1: A board with `cfg_first`=1 owns the token as soon as a cycle is active. Any other board makes no transfer, no latch and no acknowledge until `tok_in_n` is low.
- R2: In a chained read (`chain_sel`=1), each data strobe (`ds_n` low) seen by the owner moves exactly one word (`word_ready` high for one cycle). `dtack_en` rises on the cycle after the transfer and stays high until `ds_n` returns high.
- R3: A non-last board passes the token after sending the word marked `word_last`, once the strobe is released. `tok_out_n` then stays low until the cycle ends, and the board moves no further words.
- R4: An owner with no word available (`word_valid` low while no strobe is pending) passes the token without acknowledging.
- R5: A board sends at most `MAX_WORDS` words in one cycle, then gives up ownership as if its event had ended.
- R6: A board with `cfg_last`=1 never drives `tok_out_n` low. In a read, when it runs out of words, it drives `berr_n` low and holds it until the cycle ends. No other board ever drives `berr_n` low.
- R7: In a multicast write (`mcast_sel`=1), the owner pulses `wr_latch` for exactly one cycle per strobe. A non-last board then passes the token without acknowledging. The last board raises `dtack_en` until `ds_n` goes high.
- R8: Once `as_n` goes high, the next cycle shows `tok_out_n`=1, `berr_n`=1 and `dtack_en`=0, and the word count restarts for the next cycle.
- R9: With `as_n` high, or with neither select high, all strobe and token inputs are ignored and the outputs stay idle.
- R10: After reset `tok_out_n`=1, `berr_n`=1, `dtack_en`=0, `word_ready`=0 and `wr_latch`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low; the cycle lasts while it is low |
| chain_sel | input | 1 | Decoded chained-read cycle at the shared address |
| mcast_sel | input | 1 | Decoded multicast-write cycle at the shared address |
| ds_n | input | 1 | Data strobe, active low |
| tok_in_n | input | 1 | Token from the upstream board, active low |
| cfg_first | input | 1 | Board is first in the chain |
| cfg_last | input | 1 | Board is last in the chain |
| word_valid | input | 1 | Event word available from the local source |
| word_last | input | 1 | Offered word is the event's final word |
| word_ready | output | 1 | Word taken this cycle (with word_valid) |
| wr_latch | output | 1 | One-cycle pulse: latch the multicast write data |
| dtack_en | output | 1 | Drive data and acknowledge |
| tok_out_n | output | 1 | Token to the downstream board, active low |
| berr_n | output | 1 | Bus error that ends the chain, active low |

## Verification
The hardest case to reach from the ports is the word limit, because a board must hold more words than `MAX_WORDS` while the strobes keep coming. The bench builds a copy with `MAX_WORDS`=4. It sweeps event sizes from 0 to 6 words for every first/last setting, so both the limit and the empty event are hit under each role. It also ends a cycle in the middle of an event and then starts a fresh one. This shows that the count and the end-of-event flag clear on release of the address strobe and do not carry into the next cycle.

// File: rtl/chain_token_pkg.sv
package chain_token_pkg;
  typedef enum logic [2:0] {
    TK_IDLE,
    TK_WAIT,
    TK_OWN,
    TK_PASSED,
    TK_ERR
  } tok_state_t;
endpackage

// File: rtl/strobe_tracker.sv
// Remembers that the present data strobe has been served, so each strobe
// is answered once; forgets on strobe release or end of cycle.
module strobe_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ds_n,
  input  logic take,
  output logic acked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acked <= 1'b0;
    else if (!active || ds_n)  acked <= 1'b0;
    else if (take)             acked <= 1'b1;
  end
endmodule

// File: rtl/word_counter.sv
// Counts words sent in the current cycle and notes the end of the event.
module word_counter #(
  parameter int MAX_WORDS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic pop,
  input  logic pop_last,
  output logic at_max,
  output logic ended
);
  localparam int CNT_W = $clog2(MAX_WORDS + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ended <= 1'b0;
    end else if (clear) begin
      cnt   <= '0;
      ended <= 1'b0;
    end else if (pop) begin
      cnt   <= cnt + 1'b1;
      ended <= pop_last;
    end
  end

  assign at_max = (cnt == CNT_W'(MAX_WORDS));
endmodule

// File: rtl/token_fsm.sv
module token_fsm
  import chain_token_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       is_read,
  input  logic       cfg_first,
  input  logic       cfg_last,
  input  logic       tok_in_n,
  input  logic       give_up,
  output tok_state_t state
);
  tok_state_t nxt;

  always_comb begin
    nxt = state;
    if (!active) begin
      nxt = TK_IDLE;
    end else begin
      unique case (state)
        TK_IDLE: nxt = (cfg_first || !tok_in_n) ? TK_OWN : TK_WAIT;
        TK_WAIT: if (!tok_in_n) nxt = TK_OWN;
        TK_OWN: begin
          if (give_up) begin
            if (!cfg_last)    nxt = TK_PASSED;
            else if (is_read) nxt = TK_ERR;
          end
        end
        TK_PASSED: nxt = TK_PASSED;
        TK_ERR:    nxt = TK_ERR;
        default:   nxt = TK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= TK_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/chain_token_ctrl.sv
module chain_token_ctrl
  import chain_token_pkg::*;
#(
  parameter int MAX_WORDS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  logic chain_sel,
  input  logic mcast_sel,
  input  logic ds_n,
  input  logic tok_in_n,
  input  logic cfg_first,
  input  logic cfg_last,
  input  logic word_valid,
  input  logic word_last,
  output logic word_ready,
  output logic wr_latch,
  output logic dtack_en,
  output logic tok_out_n,
  output logic berr_n
);
  tok_state_t state;
  logic active, is_read, owning, strobe_go;
  logic acked, at_max, ended, pop, give_up;

  assign active    = !as_n && (chain_sel || mcast_sel);
  assign is_read   = chain_sel;
  assign owning    = (state == TK_OWN);
  assign strobe_go = owning && active && !ds_n && !acked;

  assign word_ready = strobe_go && is_read && !ended && !at_max;
  assign pop        = word_ready && word_valid;
  assign wr_latch   = strobe_go && !is_read;

  assign give_up = is_read ? (!acked && (ended || at_max || !word_valid))
                           : wr_latch;

  strobe_tracker u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .ds_n   (ds_n),
    .take   (pop || wr_latch),
    .acked  (acked)
  );

  word_counter #(.MAX_WORDS(MAX_WORDS)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!active),
    .pop      (pop),
    .pop_last (word_last),
    .at_max   (at_max),
    .ended    (ended)
  );

  token_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .is_read   (is_read),
    .cfg_first (cfg_first),
    .cfg_last  (cfg_last),
    .tok_in_n  (tok_in_n),
    .give_up   (give_up),
    .state     (state)
  );

  assign dtack_en  = acked && (is_read || cfg_last);
  assign tok_out_n = (state != TK_PASSED);
  assign berr_n    = (state != TK_ERR);
endmodule

// File: rtl/chain_token_checker.sv
module chain_token_checker #(
  parameter int MAX_WORDS = 256
) (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic chain_sel,
  input logic mcast_sel,
  input logic ds_n,
  input logic tok_in_n,
  input logic cfg_first,
  input logic cfg_last,
  input logic word_valid,
  input logic word_ready,
  input logic wr_latch,
  input logic dtack_en,
  input logic tok_out_n,
  input logic berr_n
);
  int sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        sent <= 0;
    else if (as_n)                     sent <= 0;
    else if (word_ready && word_valid) sent <= sent + 1;
  end

  assert_token_needed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready || wr_latch) |-> (cfg_first || !tok_in_n));

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && word_valid && !ds_n && !as_n) |=> dtack_en);

  assert_pass_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_out_n && !as_n && (chain_sel || mcast_sel)) |=> !tok_out_n);

  assert_word_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && word_valid) |-> (sent < MAX_WORDS));

  assert_berr_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_n |-> (cfg_last && tok_out_n));

  assert_latch_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> !wr_latch);

  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (tok_out_n && berr_n && !dtack_en));

  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n || !(chain_sel || mcast_sel)) |-> (!word_ready && !wr_latch));
endmodule

bind chain_token_ctrl chain_token_checker #(.MAX_WORDS(MAX_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .chain_sel(chain_sel),
  .mcast_sel(mcast_sel), .ds_n(ds_n), .tok_in_n(tok_in_n),
  .cfg_first(cfg_first), .cfg_last(cfg_last), .word_valid(word_valid),
  .word_ready(word_ready), .wr_latch(wr_latch), .dtack_en(dtack_en),
  .tok_out_n(tok_out_n), .berr_n(berr_n)
);

// File: tb/sim_chain_token_ctrl.sv
`timescale 1ns/1ps
module sim_chain_token_ctrl;
  localparam int MAXW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, chain_sel = 1'b0, mcast_sel = 1'b0, ds_n = 1'b1;
  logic tok_in_n = 1'b1, cfg_first = 1'b0, cfg_last = 1'b0;
  logic word_valid, word_last;
  logic word_ready, wr_latch, dtack_en, tok_out_n, berr_n;

  int supply = 0, pops = 0, latches = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  assign word_valid = (supply - pops) > 0;
  assign word_last  = (supply - pops) == 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (word_ready && word_valid) pops <= pops + 1;
    if (wr_latch) latches <= latches + 1;
  end

  chain_token_ctrl #(.MAX_WORDS(MAXW)) u0 (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .chain_sel(chain_sel),
    .mcast_sel(mcast_sel), .ds_n(ds_n), .tok_in_n(tok_in_n),
    .cfg_first(cfg_first), .cfg_last(cfg_last), .word_valid(word_valid),
    .word_last(word_last), .word_ready(word_ready), .wr_latch(wr_latch),
    .dtack_en(dtack_en), .tok_out_n(tok_out_n), .berr_n(berr_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_chk(input string req);
    chk(tok_out_n && berr_n && !dtack_en && !word_ready && !wr_latch, req,
        {tok_out_n, berr_n, dtack_en, word_ready, wr_latch}, 5'b11000);
  endtask

  task automatic release_cycle();
    @(negedge clk);
    ds_n = 1'b1; as_n = 1'b1; chain_sel = 1'b0; mcast_sel = 1'b0; tok_in_n = 1'b1;
    @(negedge clk);
    idle_chk("R8 idle after address strobe release");
    @(negedge clk);
  endtask

  task automatic run_read(input bit first, input bit last, input int n, input int limit);
    int got = 0, base, expw;
    bit fin = 0;
    supply = pops + n;
    base = pops;
    cfg_first = first; cfg_last = last; tok_in_n = 1'b1;
    @(negedge clk);
    chain_sel = 1'b1; as_n = 1'b0;
    if (!first) begin
      ds_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(tok_out_n && !dtack_en && !word_ready && pops == base,
          "R1 non-first waits for token", pops - base, 0);
      ds_n = 1'b1;
      tok_in_n = 1'b0;
    end
    for (int k = 0; k < 12 && !fin && got < limit; k++) begin
      ds_n = 1'b0;
      for (int w = 0; w < 10; w++) begin
        @(negedge clk);
        if (dtack_en || !berr_n || !tok_out_n) break;
      end
      if (dtack_en) begin
        got++;
        ds_n = 1'b1;
        for (int w = 0; w < 10; w++) begin
          @(negedge clk);
          if (!dtack_en) break;
        end
      end else fin = 1;
    end
    ds_n = 1'b1;
    if (limit > 12) begin
      expw = (n < MAXW) ? n : MAXW;
      if (n > MAXW)       chk(got == expw, "R5 word limit per cycle", got, expw);
      else if (n == 0)    chk(got == 0, "R4 empty board acks nothing", got, 0);
      else                chk(got == expw, "R2 one word per strobe", got, expw);
      chk(pops - base == expw, "R2 words taken from stream", pops - base, expw);
      if (last) begin
        chk(!berr_n, "R6 last board raises bus error", berr_n, 0);
        chk(tok_out_n, "R6 last board keeps token", tok_out_n, 1);
      end else begin
        chk(!tok_out_n, (n == 0) ? "R4 empty board passes token" : "R3 token passed",
            tok_out_n, 0);
        chk(berr_n, "R6 no bus error from non-last", berr_n, 1);
        ds_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!dtack_en && pops - base == expw, "R3 silent after pass", pops - base, expw);
        ds_n = 1'b1;
      end
    end
    release_cycle();
  endtask

  task automatic run_write(input bit first, input bit last);
    int base = latches;
    cfg_first = first; cfg_last = last; tok_in_n = 1'b1;
    @(negedge clk);
    mcast_sel = 1'b1; as_n = 1'b0; ds_n = 1'b0;
    if (!first) begin
      repeat (3) @(negedge clk);
      chk(latches == base && !dtack_en && tok_out_n, "R1 non-first write waits",
          latches - base, 0);
      tok_in_n = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk(latches - base == 1, "R7 one latch per strobe", latches - base, 1);
    chk(dtack_en == last, "R7 only last acknowledges", dtack_en, last);
    chk(tok_out_n == last, "R7 token passed by non-last", tok_out_n, last);
    chk(berr_n, "R6 no bus error on write", berr_n, 1);
    ds_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!dtack_en, "R7 acknowledge drops with strobe", dtack_en, 0);
    release_cycle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R10 idle after reset");

    // R9: strobes with no select, and select with address strobe high
    supply = pops + 3;
    cfg_first = 1'b1; cfg_last = 1'b1;
    as_n = 1'b0; ds_n = 1'b0;
    repeat (4) @(negedge clk);
    idle_chk("R9 no select ignored");
    as_n = 1'b1; chain_sel = 1'b1; mcast_sel = 1'b1;
    repeat (4) @(negedge clk);
    idle_chk("R9 address strobe high ignored");
    chk(latches == 0, "R9 no latch", latches, 0);
    chain_sel = 1'b0; mcast_sel = 1'b0; ds_n = 1'b1;
    @(negedge clk);

    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 2; l++)
        for (int n = 0; n <= MAXW + 2; n++)
          run_read(f[0], l[0], n, 99);

    // R8: cycle cut mid-event, then a fresh cycle
    run_read(1'b1, 1'b0, 3, 1);
    run_read(1'b1, 1'b0, 2, 99);

    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 2; l++)
        run_write(f[0], l[0]);

    finish_run();
  end
endmodule